// File: doc/BRIEF.md
# Load/Store Effective Address Unit

This unit is purely combinational. It forms the memory address and the base-register update for single-word and single-byte load and store instructions. It takes the 32-bit instruction word, the value of the base register, the value of the offset register and the current carry flag. The offset is either a 12-bit unsigned immediate or the offset register shifted by a 5-bit immediate amount. The unit adds that offset to the base or subtracts it, then selects the address and the write-back control for the chosen indexing mode.

It belongs in the address stage of a pipeline. The register file feeds the two operand ports. The outputs drive the memory request address and the base-register write port. A base read from the program counter must arrive already adjusted to the instruction address plus 8; the unit applies no correction of its own.

Top module: `lsag_top`

## Requirements
- R1: With bit 25 clear, the offset is bits 11:0 of the instruction, zero-extended to the data width; bit 4 plays no special role in this form.
- R2: Bit 23 set adds the offset to the base and bit 23 clear subtracts it; `wb_value` always carries that sum or difference, modulo 2^32.
- R3: With bit 24 set, `mem_addr` equals `wb_value`, which is base ± offset.
- R4: With bit 24 clear (post-indexing), `mem_addr` equals the unmodified base and `wb_en` is 1, whatever bit 21 holds.
- R5: With bit 24 set, `wb_en` follows bit 21: 1 gives pre-indexed write-back and 0 gives none.
- R6: With bit 25 set, the offset is the offset register shifted by the amount in bits 11:7. The kind comes from bits 6:5: 00 logical left, 01 logical right, 10 arithmetic right, 11 rotate right. A left shift by 0 leaves the value unchanged.
- R7: A logical-right amount of 0 means a shift by 32, which gives 0. An arithmetic-right amount of 0 means a shift by 32, which fills every bit with the sign bit.
- R8: A rotate amount of 0 means a one-bit rotate through carry: the result is the value shifted right by one, with `carry_in` in the top bit.
- R9: With bit 25 set and bit 4 set, `unsup_shift` is 1 and `wb_en` is forced to 0. In every other case `unsup_shift` is 0.
- R10: `wb_hazard` is 1 exactly when `wb_en` is 1, bit 20 (load) is set and the base index in bits 19:16 equals the destination index in bits 15:12.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| instr | input | 32 | Instruction word being executed |
| base_val | input | 32 | Base register value (program counter already adjusted) |
| ofs_reg_val | input | 32 | Offset register value |
| carry_in | input | 1 | Current carry flag, used by rotate-through-carry |
| mem_addr | output | 32 | Effective memory address |
| wb_value | output | 32 | Updated base value, base ± offset |
| wb_en | output | 1 | Base write-back enable |
| unsup_shift | output | 1 | Register-amount shift encoding seen in the offset |
| wb_hazard | output | 1 | Write-back collides with the register being loaded |

## Verification
The unit has no register between its inputs and its outputs, so every result is due in the same cycle as the stimulus that produces it. The bench changes its inputs just after a rising clock edge and reads every output at the following falling edge, half a period later, when all of them have settled. The checker evaluates its immediate assertions whenever an input changes, and skips any evaluation while an input still holds an unknown value.

// File: rtl/lsag_pkg.sv
// Package: lsag_pkg
// Holds the instruction field positions and the shared types of the
// load/store address unit. It assumes a 32-bit instruction word.
package lsag_pkg;
    localparam int INSTR_W   = 32;
    localparam int POS_REGF  = 25;   // 1: shifted register offset
    localparam int POS_PRE   = 24;   // 1: offset applied before access
    localparam int POS_UP    = 23;   // 1: add, 0: subtract
    localparam int POS_WB    = 21;   // write-back request when pre-indexed
    localparam int POS_LOAD  = 20;   // 1: load
    localparam int POS_RN_LO = 16;
    localparam int POS_RD_LO = 12;
    localparam int IDX_W     = 4;
    localparam int IMM_W     = 12;
    localparam int POS_AMT   = 7;
    localparam int AMT_W     = 5;
    localparam int POS_KIND  = 5;
    localparam int POS_RSEL  = 4;    // register-amount selector (unsupported)

    typedef enum logic [1:0] {
        SK_LSL = 2'b00,
        SK_LSR = 2'b01,
        SK_ASR = 2'b10,
        SK_ROR = 2'b11
    } shift_kind_e;

    typedef struct packed {
        logic              reg_form;
        logic              pre;
        logic              up;
        logic              wb_req;
        logic              load;
        logic [IDX_W-1:0]  rn;
        logic [IDX_W-1:0]  rd;
        logic [IMM_W-1:0]  imm;
        logic [AMT_W-1:0]  amt;
        shift_kind_e       kind;
        logic              rsel;
    } ls_ctrl_t;
endpackage

// File: rtl/lsag_decode.sv
// Module: lsag_decode
// Splits the instruction word into the control fields the address unit
// needs. It assumes that only single-word or single-byte transfers arrive here.
module lsag_decode
    import lsag_pkg::*;
(
    input  logic [INSTR_W-1:0] instr,
    output ls_ctrl_t           ctrl
);
    // Field extraction, no interpretation
    always_comb begin
        ctrl.reg_form = instr[POS_REGF];
        ctrl.pre      = instr[POS_PRE];
        ctrl.up       = instr[POS_UP];
        ctrl.wb_req   = instr[POS_WB];
        ctrl.load     = instr[POS_LOAD];
        ctrl.rn       = instr[POS_RN_LO +: IDX_W];
        ctrl.rd       = instr[POS_RD_LO +: IDX_W];
        ctrl.imm      = instr[IMM_W-1:0];
        ctrl.amt      = instr[POS_AMT +: AMT_W];
        ctrl.kind     = shift_kind_e'(instr[POS_KIND +: 2]);
        ctrl.rsel     = instr[POS_RSEL];
    end
endmodule

// File: rtl/lsag_offset.sv
// Module: lsag_offset
// Produces the unsigned offset magnitude: either the zero-extended immediate
// or the offset register shifted by an immediate amount. Amount 0 encodes
// shift-by-full-width for the right shifts and rotate-through-carry for ROR.
// It assumes that DATA_W is a power of two and no wider than 2**AMT_W.
module lsag_offset
    import lsag_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              reg_form,
    input  logic [IMM_W-1:0]  imm,
    input  logic [DATA_W-1:0] rm,
    input  logic [AMT_W-1:0]  amt,
    input  shift_kind_e       kind,
    input  logic              carry_in,
    output logic [DATA_W-1:0] offset
);
    localparam int SH_W = $clog2(DATA_W);

    logic [SH_W-1:0]     sh;
    logic                amt_zero;
    logic [2*DATA_W-1:0] rot_pair;
    logic [DATA_W-1:0]   shifted;
    logic [DATA_W-1:0]   imm_ext;

    // Immediate widening: narrow or full-width data paths
    generate
        if (DATA_W > IMM_W) begin : g_imm_pad
            assign imm_ext = {{(DATA_W-IMM_W){1'b0}}, imm};
        end else begin : g_imm_cut
            assign imm_ext = imm[DATA_W-1:0];
        end
    endgenerate

    assign sh       = amt[SH_W-1:0];
    assign amt_zero = (amt == '0);
    assign rot_pair = {rm, rm} >> sh;

    // Barrel shifter with the amount-zero special encodings
    always_comb begin
        unique case (kind)
            SK_LSL: shifted = rm << sh;
            SK_LSR: shifted = amt_zero ? '0 : (rm >> sh);
            SK_ASR: shifted = amt_zero ? {DATA_W{rm[DATA_W-1]}}
                                       : DATA_W'($signed(rm) >>> sh);
            SK_ROR: shifted = amt_zero ? {carry_in, rm[DATA_W-1:1]}
                                       : rot_pair[DATA_W-1:0];
            default: shifted = rm;
        endcase
    end

    // Choose the offset source
    always_comb offset = reg_form ? shifted : imm_ext;
endmodule

// File: rtl/lsag_combine.sv
// Module: lsag_combine
// Applies the offset in the chosen direction and selects the address,
// the write-back enable and the load/base collision flag for the indexing mode.
// It assumes that the offset magnitude is unsigned.
module lsag_combine #(
    parameter int DATA_W = 32
) (
    input  logic [DATA_W-1:0] base,
    input  logic [DATA_W-1:0] offset,
    input  logic              up,
    input  logic              pre,
    input  logic              wb_req,
    input  logic              unsup,
    input  logic              load,
    input  logic              same_reg,
    output logic [DATA_W-1:0] addr,
    output logic [DATA_W-1:0] new_base,
    output logic              wb_en,
    output logic              hazard
);
    // Offset application in the selected direction
    always_comb new_base = up ? (base + offset) : (base - offset);

    // Address comes from the updated base only when pre-indexed
    always_comb addr = pre ? new_base : base;

    // Post-indexing always writes back; pre-indexed only on request
    always_comb wb_en = !unsup && (!pre || wb_req);

    // Write-back into the register being loaded is a collision
    always_comb hazard = wb_en && load && same_reg;
endmodule

// File: rtl/lsag_top.sv
// Module: lsag_top
// Combinational effective-address unit for single-word and single-byte
// loads and stores. It assumes a base read from the program counter arrives
// already adjusted, and that a downstream stage handles alignment and access.
module lsag_top
    import lsag_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic [INSTR_W-1:0] instr,
    input  logic [DATA_W-1:0]  base_val,
    input  logic [DATA_W-1:0]  ofs_reg_val,
    input  logic               carry_in,
    output logic [DATA_W-1:0]  mem_addr,
    output logic [DATA_W-1:0]  wb_value,
    output logic               wb_en,
    output logic               unsup_shift,
    output logic               wb_hazard
);
    ls_ctrl_t          ctrl;
    logic [DATA_W-1:0] offset;
    logic              unsup;

    lsag_decode u_decode (
        .instr (instr),
        .ctrl  (ctrl)
    );

    lsag_offset #(.DATA_W(DATA_W)) u_offset (
        .reg_form (ctrl.reg_form),
        .imm      (ctrl.imm),
        .rm       (ofs_reg_val),
        .amt      (ctrl.amt),
        .kind     (ctrl.kind),
        .carry_in (carry_in),
        .offset   (offset)
    );

    // A register-amount encoding is only meaningful in the register form
    always_comb unsup = ctrl.reg_form && ctrl.rsel;

    lsag_combine #(.DATA_W(DATA_W)) u_combine (
        .base     (base_val),
        .offset   (offset),
        .up       (ctrl.up),
        .pre      (ctrl.pre),
        .wb_req   (ctrl.wb_req),
        .unsup    (unsup),
        .load     (ctrl.load),
        .same_reg (ctrl.rn == ctrl.rd),
        .addr     (mem_addr),
        .new_base (wb_value),
        .wb_en    (wb_en),
        .hazard   (wb_hazard)
    );

    assign unsup_shift = unsup;
endmodule

// File: rtl/lsag_checker.sv
// Module: lsag_checker
// Immediate assertions on the ports of lsag_top, evaluated whenever an input
// changes and skipped while any input is unknown. It assumes 32-bit data.
module lsag_checker (
    input logic [31:0] instr,
    input logic [31:0] base_val,
    input logic [31:0] ofs_reg_val,
    input logic        carry_in,
    input logic [31:0] mem_addr,
    input logic [31:0] wb_value,
    input logic        wb_en,
    input logic        unsup_shift,
    input logic        wb_hazard
);
    logic known;
    always_comb known = !$isunknown({instr, base_val, ofs_reg_val, carry_in});

    // Port relations per requirement
    always_comb begin
        if (known) begin
            if (!instr[24] && !unsup_shift)
                p_post_addr_is_base_r4: assert (mem_addr == base_val && wb_en)
                    else $error("R4 post-index address/write-back");
            if (instr[24])
                p_pre_addr_matches_wb_r3: assert (mem_addr == wb_value)
                    else $error("R3 pre-index address differs from update");
            if (instr[24] && !unsup_shift)
                p_pre_wb_follows_w_r5: assert (wb_en == instr[21])
                    else $error("R5 write-back does not follow bit 21");
            if (!instr[25] && instr[23])
                p_imm_add_r1: assert (wb_value == base_val + {20'd0, instr[11:0]})
                    else $error("R1 immediate add");
            if (!instr[25] && !instr[23])
                p_imm_sub_r2: assert (wb_value == base_val - {20'd0, instr[11:0]})
                    else $error("R2 immediate subtract");
            p_unsup_blocks_wb_r9: assert (!(unsup_shift && wb_en))
                else $error("R9 write-back with unsupported shift");
            p_hazard_needs_wb_r10: assert (!wb_hazard || (wb_en && instr[20]
                                           && instr[19:16] == instr[15:12]))
                else $error("R10 spurious hazard");
        end
    end
endmodule

bind lsag_top lsag_checker chk_i (
    .instr       (instr),
    .base_val    (base_val),
    .ofs_reg_val (ofs_reg_val),
    .carry_in    (carry_in),
    .mem_addr    (mem_addr),
    .wb_value    (wb_value),
    .wb_en       (wb_en),
    .unsup_shift (unsup_shift),
    .wb_hazard   (wb_hazard)
);

// File: tb/lsag_top_tb_top.sv
module lsag_top_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] instr = '0;
    logic [31:0] base_val = '0;
    logic [31:0] ofs_reg_val = '0;
    logic        carry_in = 1'b0;
    logic [31:0] mem_addr;
    logic [31:0] wb_value;
    logic        wb_en;
    logic        unsup_shift;
    logic        wb_hazard;
    int          n_checks = 0;
    int          n_fail = 0;
    bit          done = 1'b0;

    always #5 clk = ~clk;

    lsag_top dut_i (
        .instr       (instr),
        .base_val    (base_val),
        .ofs_reg_val (ofs_reg_val),
        .carry_in    (carry_in),
        .mem_addr    (mem_addr),
        .wb_value    (wb_value),
        .wb_en       (wb_en),
        .unsup_shift (unsup_shift),
        .wb_hazard   (wb_hazard)
    );

    typedef struct packed {
        logic        i, p, u, w, l;
        logic [11:0] low;
        logic [31:0] base;
        logic [31:0] rm;
        logic        c;
        logic [31:0] e_addr;
        logic [31:0] e_wb;
        logic        e_en;
    } vec_t;

    localparam int NV = 15;
    localparam vec_t VEC [NV] = '{
        // R1 R3 R5: pre, add, no write-back
        '{1'b0,1'b1,1'b1,1'b0,1'b1,12'h123,32'h1000,32'h0,1'b0,32'h1123,32'h1123,1'b0},
        // R2: pre, subtract
        '{1'b0,1'b1,1'b0,1'b0,1'b1,12'h010,32'h1000,32'h0,1'b0,32'h0FF0,32'h0FF0,1'b0},
        // R5: pre-indexed write-back
        '{1'b0,1'b1,1'b1,1'b1,1'b0,12'h004,32'h2000,32'h0,1'b0,32'h2004,32'h2004,1'b1},
        // R4: post, add
        '{1'b0,1'b0,1'b1,1'b0,1'b1,12'h008,32'h3000,32'h0,1'b0,32'h3000,32'h3008,1'b1},
        // R4: post, subtract, W set
        '{1'b0,1'b0,1'b0,1'b1,1'b0,12'h008,32'h3000,32'h0,1'b0,32'h3000,32'h2FF8,1'b1},
        // R6: LSL #2
        '{1'b1,1'b1,1'b1,1'b0,1'b1,12'h101,32'h100,32'h10,1'b0,32'h140,32'h140,1'b0},
        // R6: LSR #4, subtract
        '{1'b1,1'b1,1'b0,1'b0,1'b1,12'h221,32'h100,32'hF0,1'b0,32'hF1,32'hF1,1'b0},
        // R7: LSR #0 means 32
        '{1'b1,1'b1,1'b1,1'b0,1'b1,12'h021,32'h500,32'h80000000,1'b0,32'h500,32'h500,1'b0},
        // R7: ASR #0 means 32
        '{1'b1,1'b1,1'b1,1'b0,1'b1,12'h041,32'h10,32'h80000000,1'b0,32'hF,32'hF,1'b0},
        // R6: ASR #4
        '{1'b1,1'b1,1'b1,1'b0,1'b1,12'h241,32'h0,32'h80000000,1'b0,32'hF8000000,32'hF8000000,1'b0},
        // R6: ROR #8
        '{1'b1,1'b1,1'b1,1'b0,1'b1,12'h461,32'h1,32'hAB,1'b0,32'hAB000001,32'hAB000001,1'b0},
        // R8: RRX, carry 1
        '{1'b1,1'b1,1'b1,1'b0,1'b1,12'h061,32'h0,32'h3,1'b1,32'h80000001,32'h80000001,1'b0},
        // R8: RRX, carry 0, subtract
        '{1'b1,1'b1,1'b0,1'b0,1'b1,12'h061,32'h10,32'h3,1'b0,32'hF,32'hF,1'b0},
        // R6: LSL #0 unchanged
        '{1'b1,1'b1,1'b1,1'b0,1'b1,12'h001,32'h0,32'h1234,1'b0,32'h1234,32'h1234,1'b0},
        // R1 R2: maximum immediate, subtract with wrap
        '{1'b0,1'b1,1'b0,1'b0,1'b1,12'hFFF,32'h0,32'h0,1'b0,32'hFFFFF001,32'hFFFFF001,1'b0}
    };

    function automatic logic [31:0] mk(input logic i, p, u, w, l,
                                       input logic [3:0] rn, rd,
                                       input logic [11:0] low);
        return {4'hE, 2'b01, i, p, u, 1'b0, w, l, rn, rd, low};
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic drive(input logic [31:0] ins, input logic [31:0] b,
                         input logic [31:0] r, input logic c);
        @(posedge clk);
        #1;
        instr = ins;
        base_val = b;
        ofs_reg_val = r;
        carry_in = c;
        @(negedge clk);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        // Reset-time inputs all zero: post-index, subtract zero (R4)
        drive('0, '0, '0, 1'b0);
        chk("R4 idle addr", mem_addr, 32'h0);
        chk("R4 idle wb_en", {31'd0, wb_en}, 32'd1);
        chk("R9 idle unsup", {31'd0, unsup_shift}, 32'd0);

        for (int k = 0; k < NV; k++) begin
            drive(mk(VEC[k].i, VEC[k].p, VEC[k].u, VEC[k].w, VEC[k].l,
                     4'd2, 4'd5, VEC[k].low), VEC[k].base, VEC[k].rm, VEC[k].c);
            chk($sformatf("R3/R4 vector %0d addr", k), mem_addr, VEC[k].e_addr);
            chk($sformatf("R2 vector %0d wb_value", k), wb_value, VEC[k].e_wb);
            chk($sformatf("R5 vector %0d wb_en", k), {31'd0, wb_en}, {31'd0, VEC[k].e_en});
        end

        // R9: register-amount selector in register form
        drive(mk(1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 4'd2, 4'd5, 12'h011), 32'h40, 32'h1, 1'b0);
        chk("R9 unsup flag", {31'd0, unsup_shift}, 32'd1);
        chk("R9 wb_en forced off", {31'd0, wb_en}, 32'd0);
        // R9 R1: bit 4 in immediate form is just offset data
        drive(mk(1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 4'd2, 4'd5, 12'h011), 32'h0, 32'h0, 1'b0);
        chk("R9 imm form no flag", {31'd0, unsup_shift}, 32'd0);
        chk("R1 imm form bit4 offset", mem_addr, 32'h11);

        // R10: collision cases
        drive(mk(1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 4'd3, 4'd3, 12'h4), 32'h0, 32'h0, 1'b0);
        chk("R10 post load same reg", {31'd0, wb_hazard}, 32'd1);
        drive(mk(1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 4'd3, 4'd3, 12'h4), 32'h0, 32'h0, 1'b0);
        chk("R10 store same reg", {31'd0, wb_hazard}, 32'd0);
        drive(mk(1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 4'd3, 4'd3, 12'h4), 32'h0, 32'h0, 1'b0);
        chk("R10 no write-back", {31'd0, wb_hazard}, 32'd0);
        drive(mk(1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 4'd3, 4'd3, 12'h4), 32'h0, 32'h0, 1'b0);
        chk("R10 pre-indexed load same reg", {31'd0, wb_hazard}, 32'd1);
        drive(mk(1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 4'd3, 4'd4, 12'h4), 32'h0, 32'h0, 1'b0);
        chk("R10 different regs", {31'd0, wb_hazard}, 32'd0);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end
endmodule